// File: doc/BRIEF.md
# Serial ADC Control-Byte Front End

This block is the digital side of the serial port of a two-channel, 8-bit sampling converter. It runs on a fast system clock and treats the chip-select, serial-clock and data-in pins as asynchronous. Each pin passes through a two-flop synchroniser. The serial clock is then edge-detected against the system clock, which must run at least eight times faster than the serial clock.

After chip select goes low, the block waits for the first 1 on the data line. That 1 is the top bit of an 8-bit control byte. The remaining seven bits are shifted in on rising serial-clock edges. Two falling edges at fixed positions in the byte control the sampling stage:
- the falling edge after the fourth bit opens tracking;
- the falling edge after the sixth bit closes it into hold, pulses a conversion start and latches the decoded fields.

When the sampling stage reports completion, the block returns the stage to tracking and loads the result. The result is then presented MSB first on the serial output, and each falling serial-clock edge advances it one bit. The output driver is enabled only while chip select is low.

Top module: `sadc_ctrl_front`

## Requirements
- R1: While chip select is low and no start bit has arrived, a rising serial-clock edge with data 0 has no effect. The first 1 sampled on a rising edge is the top bit (bit 7) of the control byte.
- R2: On the falling edge that follows the sixth control bit, the block latches the channel select from control bits 6..4 onto `ch_sel` (bit 6 is the MSB). Control bit 3 goes onto `clk_int` and control bit 2 onto `ref_int`.
- R3: After the eighth control bit, control bits 1..0 appear unchanged on `mode` (bit 1 is the MSB).
- R4: `track` stays low through the third control bit and rises on the falling edge that follows the fourth control bit. `track` and `hold` are never high together.
- R5: On the falling edge that follows the sixth control bit, `hold` rises, `track` falls, and `conv_start` pulses high for exactly one system cycle. No new hold is taken while a hold is already active.
- R6: `sdo_en` is low while chip select is high. Within three system cycles of chip select falling, `sdo_en` goes high and `sdo` is 0.
- R7: A `conv_done` pulse while `hold` is high makes `hold` fall and `track` rise on the next cycle.
- R8: When a conversion completes, `sdo` shows result bit 7. Each later falling serial-clock edge with chip select low advances `sdo` one bit towards the LSB.
- R9: If chip select rises before the byte completes, the partial byte is discarded, `track` is cleared (when not holding), and the next frame is framed afresh from a new start bit.
- R10: Once all eight control bits have arrived, further serial-clock edges up to the next rise of chip select do not start a new frame or a new conversion. This holds even when data is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (at least 8x the serial clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial data in, sampled on rising `sclk` |
| conv_done | input | 1 | One-cycle pulse from the sampling stage when a conversion ends |
| conv_result | input | 8 | Conversion result, valid with `conv_done` |
| track | output | 1 | Sampling stage in track mode |
| hold | output | 1 | Sampling stage in hold mode, conversion running |
| conv_start | output | 1 | One-cycle conversion start pulse |
| ch_sel | output | 3 | Decoded input pairing select |
| clk_int | output | 1 | Decoded conversion clock select |
| ref_int | output | 1 | Decoded reference select |
| mode | output | 2 | Control bits 1..0, passed through |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output driver enable for `sdo` (high = driven) |

## Verification
A pin change takes two synchroniser flops plus one state register to show up. So every pin-driven result, including `sdo_en`, `track`, `hold`, the fields and the `sdo` shift, is due on the third system clock edge after the pin moves. The bench drives pins on falling system-clock edges and waits six cycles after every serial-clock fall, or after every chip-select change, before sampling. `conv_done` passes through only the state register, so its effects are checked two cycles after the pulse. The one-cycle `conv_start` pulse cannot be caught by a delayed sample, so a monitor counts it on every cycle and the checks compare that count.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic [1:0] {
        FR_HUNT  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DONE  = 2'd2
    } fr_state_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_V}};
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
    import sadc_pkg::*;
#(
    parameter int CTRL_W    = 8,
    parameter int SEL_W     = 3,
    parameter int TRACK_BIT = 4,
    parameter int HOLD_BIT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             sclk_s,
    input  logic             din_s,
    input  logic             conv_done,
    output logic             result_load,
    output logic             track,
    output logic             hold,
    output logic             conv_start,
    output logic [SEL_W-1:0] ch_sel,
    output logic             clk_int,
    output logic             ref_int,
    output logic [1:0]       mode
);
    localparam int CNT_W = $clog2(CTRL_W + 1);
    localparam int SEL_HI = HOLD_BIT - 2;

    typedef struct packed {
        fr_state_e         st;
        logic [CTRL_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_p;
        logic              track;
        logic              hold;
        logic              start;
        logic [SEL_W-1:0]  sel;
        logic              clk_int;
        logic              ref_int;
        logic [1:0]        mode;
    } fr_t;

    fr_t fr_d, fr_q;
    logic rise, fall;

    assign rise = sclk_s & ~fr_q.sclk_p;
    assign fall = ~sclk_s & fr_q.sclk_p;
    assign result_load = conv_done & fr_q.hold;

    always_comb begin
        fr_d        = fr_q;
        fr_d.start  = 1'b0;
        fr_d.sclk_p = sclk_s;
        if (result_load) begin
            fr_d.hold  = 1'b0;
            fr_d.track = 1'b1;
        end
        if (cs_s) begin
            fr_d.st  = FR_HUNT;
            fr_d.cnt = '0;
            fr_d.sr  = '0;
            if (!fr_q.hold) fr_d.track = 1'b0;
        end else begin
            unique case (fr_q.st)
                FR_HUNT: begin
                    if (rise && din_s) begin
                        fr_d.sr  = CTRL_W'(1);
                        fr_d.cnt = CNT_W'(1);
                        fr_d.st  = FR_SHIFT;
                    end
                end
                FR_SHIFT: begin
                    if (rise) begin
                        fr_d.sr  = {fr_q.sr[CTRL_W-2:0], din_s};
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                        if (fr_q.cnt == CNT_W'(CTRL_W - 1)) begin
                            fr_d.st   = FR_DONE;
                            fr_d.mode = {fr_q.sr[0], din_s};
                        end
                    end else if (fall) begin
                        if (fr_q.cnt == CNT_W'(TRACK_BIT) && !fr_q.hold)
                            fr_d.track = 1'b1;
                        if (fr_q.cnt == CNT_W'(HOLD_BIT) && !fr_q.hold) begin
                            fr_d.hold    = 1'b1;
                            fr_d.track   = 1'b0;
                            fr_d.start   = 1'b1;
                            fr_d.sel     = fr_q.sr[SEL_HI -: SEL_W];
                            fr_d.clk_int = fr_q.sr[1];
                            fr_d.ref_int = fr_q.sr[0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= FR_HUNT;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign track      = fr_q.track;
    assign hold       = fr_q.hold;
    assign conv_start = fr_q.start;
    assign ch_sel     = fr_q.sel;
    assign clk_int    = fr_q.clk_int;
    assign ref_int    = fr_q.ref_int;
    assign mode       = fr_q.mode;

    // R1
    lead_zero_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == FR_HUNT && !cs_s && rise && !din_s) |=> fr_q.st == FR_HUNT);
    // R4
    track_hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fr_q.track && fr_q.hold));
    // R5
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.start |=> !fr_q.start);
    // R5
    start_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.start) |-> fr_q.hold);
    // R7
    done_back_to_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && fr_q.hold) |=> (!fr_q.hold && fr_q.track));
    // R9
    cs_abort_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && fr_q.st != FR_HUNT) |=> fr_q.st == FR_HUNT);
endmodule

// File: rtl/sadc_sdo.sv
module sadc_sdo #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             sclk_s,
    input  logic             load,
    input  logic [RES_W-1:0] result,
    output logic             sdo,
    output logic             sdo_en
);
    typedef struct packed {
        logic             en;
        logic             cs_p;
        logic             sclk_p;
        logic [RES_W-1:0] sr;
    } so_t;

    so_t so_d, so_q;

    always_comb begin
        so_d        = so_q;
        so_d.en     = ~cs_s;
        so_d.cs_p   = cs_s;
        so_d.sclk_p = sclk_s;
        if (load)
            so_d.sr = result;
        else if (so_q.cs_p && !cs_s)
            so_d.sr = '0;
        else if (!cs_s && so_q.sclk_p && !sclk_s)
            so_d.sr = {so_q.sr[RES_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q      <= '0;
            so_q.cs_p <= 1'b1;
        end else begin
            so_q <= so_d;
        end
    end

    assign sdo    = so_q.en & so_q.sr[RES_W-1];
    assign sdo_en = so_q.en;

    // R6
    sdo_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !so_q.en |-> !sdo);
    // R8
    sdo_load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> so_q.sr == $past(result));
endmodule

// File: rtl/sadc_ctrl_front.sv
module sadc_ctrl_front #(
    parameter int CTRL_W    = 8,
    parameter int RES_W     = 8,
    parameter int SEL_W     = 3,
    parameter int SYNC_N    = 2,
    parameter int TRACK_BIT = 4,
    parameter int HOLD_BIT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             track,
    output logic             hold,
    output logic             conv_start,
    output logic [SEL_W-1:0] ch_sel,
    output logic             clk_int,
    output logic             ref_int,
    output logic [1:0]       mode,
    output logic             sdo,
    output logic             sdo_en
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic cs_s, sclk_s, din_s, result_load;

    sadc_sync #(.W(PIN_W), .STAGES(SYNC_N), .RST_V(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_n, sclk, din}),
        .sync_o(pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign din_s  = pins_s[0];

    sadc_frame #(.CTRL_W(CTRL_W), .SEL_W(SEL_W), .TRACK_BIT(TRACK_BIT),
                 .HOLD_BIT(HOLD_BIT)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .sclk_s(sclk_s), .din_s(din_s),
        .conv_done(conv_done), .result_load(result_load),
        .track(track), .hold(hold), .conv_start(conv_start),
        .ch_sel(ch_sel), .clk_int(clk_int), .ref_int(ref_int), .mode(mode)
    );

    sadc_sdo #(.RES_W(RES_W)) u_sdo (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .sclk_s(sclk_s),
        .load(result_load), .result(conv_result),
        .sdo(sdo), .sdo_en(sdo_en)
    );
endmodule

// File: tb/sadc_ctrl_front_test.sv
module sadc_ctrl_front_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] conv_result = '0;
    logic       track, hold, conv_start, clk_int, ref_int, sdo, sdo_en;
    logic [2:0] ch_sel;
    logic [1:0] mode;
    int n_chk = 0, n_bad = 0, n_starts = 0;

    always #2.5 clk = ~clk;

    sadc_ctrl_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .conv_done(conv_done), .conv_result(conv_result),
        .track(track), .hold(hold), .conv_start(conv_start),
        .ch_sel(ch_sel), .clk_int(clk_int), .ref_int(ref_int), .mode(mode),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    always @(negedge clk) if (rst_n && conv_start) n_starts++;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        @(negedge clk) din = b;
        wait_cyc(8);
        sclk = 1'b1;
        wait_cyc(8);
        sclk = 1'b0;
        wait_cyc(6);
    endtask

    task automatic set_cs(logic v);
        @(negedge clk) cs_n = v;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        check("R6 reset sdo_en", sdo_en, 0);
        check("R4 reset track", track, 0);
        check("R5 reset hold", hold, 0);
        check("R5 reset starts", n_starts, 0);
    endtask

    // sends zeros then a control byte, checking the fall-edge effects
    task automatic t_frame(int zeros, logic [7:0] cb);
        int s0 = n_starts;
        set_cs(1'b0);
        check("R6 sdo_en after cs fall", sdo_en, 1);
        check("R6 sdo low after cs fall", sdo, 0);
        for (int i = 0; i < zeros; i++) send_bit(1'b0);
        check("R1 no track during leading zeros", track, 0);
        check("R1 no start during leading zeros", n_starts, s0);
        for (int i = 7; i >= 0; i--) begin
            send_bit(cb[i]);
            if (i == 5) check("R4 track low after bit 3", track, 0);
            if (i == 4) check("R4 track high after bit 4", track, 1);
            if (i == 2) begin
                check("R5 hold after bit 6", hold, 1);
                check("R5 track dropped at hold", track, 0);
                check("R5 one start pulse", n_starts, s0 + 1);
                check("R2 ch_sel", ch_sel, cb[6:4]);
                check("R2 clk_int", clk_int, cb[3]);
                check("R2 ref_int", ref_int, cb[2]);
            end
        end
        check("R3 mode bits", mode, cb[1:0]);
    endtask

    task automatic t_readout(logic [7:0] res);
        int s0 = n_starts;
        @(negedge clk) begin conv_done = 1'b1; conv_result = res; end
        @(negedge clk) conv_done = 1'b0;
        wait_cyc(1);
        check("R7 hold cleared", hold, 0);
        check("R7 track restored", track, 1);
        check("R8 first bit is MSB", sdo, res[7]);
        for (int k = 1; k < 8; k++) begin
            send_bit(1'b1);
            check("R8 shifted bit", sdo, res[7-k]);
        end
        check("R10 no restart after full byte", n_starts, s0);
        set_cs(1'b1);
        check("R6 sdo_en off with cs high", sdo_en, 0);
        check("R9 track cleared at cs rise", track, 0);
    endtask

    task automatic t_abort();
        int s0 = n_starts;
        set_cs(1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check("R9 track before abort", track, 1);
        set_cs(1'b1);
        check("R9 track cleared on abort", track, 0);
        check("R9 no start on abort", n_starts, s0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset();
        t_frame(3, 8'hBA);
        t_readout(8'hA5);
        t_abort();
        t_frame(0, 8'h8D);
        t_readout(8'h3C);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule